// File: doc/BRIEF.md
# Digital Pin Trigger Combiner

This block watches two external trigger pins and turns their level and edge activity into a digital trigger. It then merges that trigger with an analog threshold flag for each of two trigger paths. Each pin is first brought into the clock domain through a two-flop synchronizer. Edges are found by comparing the synchronized level with its value one cycle earlier. Five condition detectors per pin (low level, high level, any edge, rising edge, falling edge) can each be enabled on its own, and the pin's result is the OR of the enabled detectors.

Each path takes pin 0's result as its digital input and pairs it with its own analog flag. A 4-bit mode code selects one of ten Boolean mixes. Both path triggers are registered, and the per-pin results are also brought out registered, so that other logic can use pin 1.

Top module: `trig_combiner_top`

## Requirements
- R1: While `rst_n` is low, `trig_a`, `trig_b` and `pin_hit` are all 0.
- R2: In `cond_en`, condition c of pin p is enabled by bit 2*c+p, with c = 0 low level, 1 high level, 2 any edge, 3 rising edge, 4 falling edge. Pin 0 therefore uses the even bits and pin 1 the odd bits.
- R3: The level conditions test the synchronized pin level. Low level fires while it is 0 and high level fires while it is 1.
- R4: The edge conditions compare the synchronized level with its value one cycle earlier. Rising fires on 0 to 1, falling on 1 to 0 and any edge on either. Each fires for exactly one cycle per transition.
- R5: `pin_hit[p]` is the OR of all enabled conditions of pin p. It is 0 when none of that pin's enable bits is set.
- R6: A level change on `pin_in` that stays stable first shows on `pin_hit` at the third rising clock edge after the change.
- R7: Mode codes 0, 1 and 2 give, in that order, a constant 1, the digital trigger alone, and the analog flag alone.
- R8: Mode codes 4, 5 and 6 give the digital trigger OR, AND and XOR the analog flag, in that order.
- R9: Mode codes 7, 8 and 9 give the inverse of modes 4, 5 and 6 respectively.
- R10: Mode code 3 and codes 10 to 15 give a constant 0.
- R11: Both paths take pin 0's result as their digital input. Pin 1's conditions appear only on `pin_hit[1]`.
- R12: A change on `ana_a`, `ana_b`, `mode_a` or `mode_b` shows on the matching trigger at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 2 | Raw levels of the two external trigger pins |
| cond_en | input | 10 | Condition enable word, layout per R2 |
| ana_a | input | 1 | Analog trigger flag for path A |
| ana_b | input | 1 | Analog trigger flag for path B |
| mode_a | input | 4 | Mix mode for path A |
| mode_b | input | 4 | Mix mode for path B |
| trig_a | output | 1 | Registered trigger of path A |
| trig_b | output | 1 | Registered trigger of path B |
| pin_hit | output | 2 | Registered per-pin digital result |

## Verification
The assertions check the following on every cycle:
- Reserved mode codes force the trigger low.
- Mode 0 forces it high.
- The OR mode on path A and the inverted AND mode on path B follow the pin 0 result and the analog flag from the previous cycle.
- Both paths agree when both are in digital-only mode.
- An all-zero enable word leaves `pin_hit` low.

Only the bench's scenarios can show the synchronizer latency, the one-cycle width of the edge pulses and the bit layout of the enable word. These need a history of pin activity and a model of the expected pipeline.

// File: rtl/trig_cmb_pkg.sv
package trig_cmb_pkg;

  localparam int unsigned COND_NUM = 5;
  localparam int unsigned MODE_W   = 4;

  typedef enum logic [2:0] {
    C_LOW  = 3'd0,
    C_HIGH = 3'd1,
    C_ANY  = 3'd2,
    C_RISE = 3'd3,
    C_FALL = 3'd4
  } cond_e;

  typedef enum logic [MODE_W-1:0] {
    M_ALWAYS = 4'd0,
    M_DIG    = 4'd1,
    M_ANA    = 4'd2,
    M_RSVD   = 4'd3,
    M_OR     = 4'd4,
    M_AND    = 4'd5,
    M_XOR    = 4'd6,
    M_NOR    = 4'd7,
    M_NAND   = 4'd8,
    M_XNOR   = 4'd9
  } mode_e;

  // OR of the enabled detectors for one pin, from current and previous level
  function automatic logic cond_eval(input logic [COND_NUM-1:0] en,
                                     input logic lvl, input logic prv);
    logic [COND_NUM-1:0] ev;
    ev         = '0;
    ev[C_LOW]  = ~lvl;
    ev[C_HIGH] = lvl;
    ev[C_ANY]  = lvl ^ prv;
    ev[C_RISE] = lvl & ~prv;
    ev[C_FALL] = ~lvl & prv;
    return |(ev & en);
  endfunction

  // Boolean mix of digital and analog trigger for a path
  function automatic logic mix_eval(input logic [MODE_W-1:0] mode,
                                    input logic d, input logic a);
    logic r;
    case (mode_e'(mode))
      M_ALWAYS: r = 1'b1;
      M_DIG:    r = d;
      M_ANA:    r = a;
      M_OR:     r = d | a;
      M_AND:    r = d & a;
      M_XOR:    r = d ^ a;
      M_NOR:    r = ~(d | a);
      M_NAND:   r = ~(d & a);
      M_XNOR:   r = ~(d ^ a);
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/trig_pin_sync.sv
module trig_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic prv
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], d};
  end

  assign lvl = sh[STAGES-1];
  assign prv = sh[STAGES];
endmodule

// File: rtl/trig_pin_detect.sv
module trig_pin_detect
  import trig_cmb_pkg::*;
#(
  parameter int unsigned NUM_PINS = 2,
  parameter int unsigned PIN_IDX  = 0,
  localparam int unsigned EN_W    = NUM_PINS * COND_NUM
) (
  input  logic [EN_W-1:0] cond_en,
  input  logic            lvl,
  input  logic            prv,
  output logic            hit
);
  logic [COND_NUM-1:0] pin_en;

  // gather this pin's interleaved enable bits
  for (genvar c = 0; c < COND_NUM; c++) begin : g_sel
    assign pin_en[c] = cond_en[c*NUM_PINS + PIN_IDX];
  end

  assign hit = cond_eval(pin_en, lvl, prv);
endmodule

// File: rtl/trig_path_mixer.sv
module trig_path_mixer
  import trig_cmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              dig,
  input  logic              ana,
  output logic              trig
);
  logic mix_now;
  assign mix_now = mix_eval(mode, dig, ana);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig <= 1'b0;
    else        trig <= mix_now;
  end
endmodule

// File: rtl/trig_combiner_top.sv
module trig_combiner_top
  import trig_cmb_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIG_PIN     = 0,
  localparam int unsigned EN_W       = NUM_PINS * COND_NUM
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [EN_W-1:0]     cond_en,
  input  logic                ana_a,
  input  logic                ana_b,
  input  logic [MODE_W-1:0]   mode_a,
  input  logic [MODE_W-1:0]   mode_b,
  output logic                trig_a,
  output logic                trig_b,
  output logic [NUM_PINS-1:0] pin_hit
);
  localparam int unsigned NUM_PATHS = 2;

  logic [NUM_PINS-1:0] sync_lvl;
  logic [NUM_PINS-1:0] sync_prv;
  logic [NUM_PINS-1:0] hit_now;   // combinational per-pin result

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    trig_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in[p]),
      .lvl   (sync_lvl[p]),
      .prv   (sync_prv[p])
    );
    trig_pin_detect #(.NUM_PINS(NUM_PINS), .PIN_IDX(p)) u_det (
      .cond_en (cond_en),
      .lvl     (sync_lvl[p]),
      .prv     (sync_prv[p]),
      .hit     (hit_now[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_hit <= '0;
    else        pin_hit <= hit_now;
  end

  logic [NUM_PATHS-1:0]             path_ana;
  logic [NUM_PATHS-1:0][MODE_W-1:0] path_mode;
  logic [NUM_PATHS-1:0]             path_trig;

  assign path_ana  = {ana_b, ana_a};
  assign path_mode = {mode_b, mode_a};

  for (genvar k = 0; k < NUM_PATHS; k++) begin : g_path
    trig_path_mixer u_mix (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (path_mode[k]),
      .dig   (hit_now[DIG_PIN]),
      .ana   (path_ana[k]),
      .trig  (path_trig[k])
    );
  end

  assign trig_a = path_trig[0];
  assign trig_b = path_trig[1];
endmodule

// File: rtl/trig_combiner_chk.sv
module trig_combiner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [9:0] cond_en,
  input logic       ana_a,
  input logic       ana_b,
  input logic [3:0] mode_a,
  input logic [3:0] mode_b,
  input logic       trig_a,
  input logic       trig_b,
  input logic [1:0] pin_hit,
  input logic [1:0] hit_now
);
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == 4'd3 || mode_a > 4'd9) |=> !trig_a);

  a_r7_always_on: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b == 4'd0) |=> trig_b);

  a_r8_or_mix: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == 4'd4) |=> (trig_a == ($past(hit_now[0]) | $past(ana_a))));

  a_r9_nand_mix: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b == 4'd8) |=> (trig_b == !($past(hit_now[0]) & $past(ana_b))));

  a_r11_shared_digital: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == 4'd1 && mode_b == 4'd1) |=> (trig_a == trig_b));

  a_r5_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_en == 10'd0) |=> (pin_hit == 2'b00));
endmodule

bind trig_combiner_top trig_combiner_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cond_en (cond_en),
  .ana_a   (ana_a),
  .ana_b   (ana_b),
  .mode_a  (mode_a),
  .mode_b  (mode_b),
  .trig_a  (trig_a),
  .trig_b  (trig_b),
  .pin_hit (pin_hit),
  .hit_now (hit_now)
);

// File: tb/trig_combiner_top_bench.sv
module trig_combiner_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin_in = '0;
  logic [9:0] cond_en = '0;
  logic       ana_a = 1'b0, ana_b = 1'b0;
  logic [3:0] mode_a = '0, mode_b = '0;
  logic       trig_a, trig_b;
  logic [1:0] pin_hit;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  trig_combiner_top u_trig_combiner_top (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cond_en(cond_en),
    .ana_a(ana_a), .ana_b(ana_b), .mode_a(mode_a), .mode_b(mode_b),
    .trig_a(trig_a), .trig_b(trig_b), .pin_hit(pin_hit)
  );

  // bench view of a pin condition: walk the enable bits by position 2*c+p
  function automatic logic b_cond(input logic [9:0] en, input int p,
                                  input logic cur, input logic old);
    logic r = 1'b0;
    for (int c = 0; c < 5; c++) begin
      if (en[2*c+p]) begin
        if (c == 0 && !cur) r = 1'b1;
        if (c == 1 && cur) r = 1'b1;
        if (c == 2 && cur != old) r = 1'b1;
        if (c == 3 && cur && !old) r = 1'b1;
        if (c == 4 && !cur && old) r = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic b_mix(input logic [3:0] m, input logic d, input logic a);
    logic base;
    if (m == 0) return 1'b1;
    if (m == 1) return d;
    if (m == 2) return a;
    if (m < 4 || m > 9) return 1'b0;
    case ((int'(m) - 4) % 3)
      0: base = d | a;
      1: base = d & a;
      default: base = d ^ a;
    endcase
    return (m >= 7) ? ~base : base;
  endfunction

  function automatic string mtag(input logic [3:0] m);
    if (m <= 2) return "R7";
    if (m >= 4 && m <= 6) return "R8";
    if (m >= 7 && m <= 9) return "R9";
    return "R10";
  endfunction

  // reference pipeline
  logic [1:0] ms1 = '0, ms2 = '0, mprv = '0, e_hit = '0;
  logic e_a = 1'b0, e_b = 1'b0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms1 <= '0; ms2 <= '0; mprv <= '0; e_hit <= '0; e_a <= 1'b0; e_b <= 1'b0;
    end else begin
      ms1 <= pin_in; ms2 <= ms1; mprv <= ms2;
      e_hit[0] <= b_cond(cond_en, 0, ms2[0], mprv[0]);
      e_hit[1] <= b_cond(cond_en, 1, ms2[1], mprv[1]);
      e_a <= b_mix(mode_a, b_cond(cond_en, 0, ms2[0], mprv[0]), ana_a);
      e_b <= b_mix(mode_b, b_cond(cond_en, 0, ms2[0], mprv[0]), ana_b);
    end
  end

  task automatic chk(input string tag, input logic act, input logic expv, input string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, expv, $time);
    end
  endtask

  // wait for the falling edge and compare all outputs with the model
  task automatic step();
    @(negedge clk);
    chk(mtag(mode_a), trig_a, e_a, "trig_a");
    chk(mtag(mode_b), trig_b, e_b, "trig_b");
    chk("R5", pin_hit[0], e_hit[0], "pin_hit0");
    chk("R5", pin_hit[1], e_hit[1], "pin_hit1");
  endtask

  initial begin
    #1600000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state, with inputs that would otherwise trigger
    cond_en = 10'h3FF; mode_a = 4'd0; mode_b = 4'd0; ana_a = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R1", trig_a, 1'b0, "trig_a in reset");
      chk("R1", trig_b, 1'b0, "trig_b in reset");
      chk("R1", pin_hit[0] | pin_hit[1], 1'b0, "pin_hit in reset");
    end
    cond_en = '0; mode_a = 4'd1; mode_b = 4'd1; ana_a = 1'b0;
    rst_n = 1'b1;
    repeat (4) step();

    // R6 / R3: pin 0 high level, latency of a rise
    cond_en = 10'b00_0000_0100;
    repeat (3) step();
    pin_in[0] = 1'b1;
    step(); chk("R6", pin_hit[0], 1'b0, "edge 1");
    step(); chk("R6", pin_hit[0], 1'b0, "edge 2");
    step(); chk("R6", pin_hit[0], 1'b1, "edge 3");
    chk("R3", trig_a, 1'b1, "high level via mode 1");
    step(); chk("R3", pin_hit[0], 1'b1, "high level held");

    // R4: rising edge on pin 0 is a single-cycle pulse
    cond_en = 10'b00_0100_0000;
    pin_in[0] = 1'b0;
    repeat (4) step();
    pin_in[0] = 1'b1;
    step(); step(); step(); chk("R4", pin_hit[0], 1'b1, "rise pulse");
    step(); chk("R4", pin_hit[0], 1'b0, "rise pulse ends");

    // R2 / R11: only pin 1 falling-edge enable (bit 9) set
    cond_en = 10'b10_0000_0000;
    pin_in[1] = 1'b1;
    repeat (4) step();
    pin_in[1] = 1'b0;
    step(); step(); step();
    chk("R2", pin_hit[1], 1'b1, "pin1 fall via bit 9");
    chk("R11", trig_a, 1'b0, "pin1 does not reach path A");
    chk("R11", trig_b, 1'b0, "pin1 does not reach path B");
    step();

    // R3: pin 1 low level (bit 1)
    cond_en = 10'b00_0000_0010;
    step(); chk("R3", pin_hit[1], 1'b1, "pin1 low level");

    // R10 / R12: reserved mode, then mode 2 with analog flag
    mode_a = 4'd3; mode_b = 4'd12; ana_a = 1'b1; ana_b = 1'b1; cond_en = 10'h3FF;
    step(); chk("R10", trig_a, 1'b0, "mode 3"); chk("R10", trig_b, 1'b0, "mode 12");
    mode_a = 4'd2; ana_a = 1'b1;
    step(); chk("R12", trig_a, 1'b1, "analog next edge");
    ana_a = 1'b0;
    step(); chk("R12", trig_a, 1'b0, "analog drop next edge");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) pin_in = 2'($urandom);
      if ($urandom_range(0, 7) == 0) cond_en = 10'($urandom);
      ana_a = 1'($urandom); ana_b = 1'($urandom);
      if ($urandom_range(0, 3) == 0) mode_a = 4'($urandom);
      if ($urandom_range(0, 3) == 0) mode_b = 4'($urandom);
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule